// File: doc/BRIEF.md
# Interrupt Message Queue Register Window

This block buffers interrupt messages that arrive at the root-complex side of a bridge. It then hands them to software one at a time through a pair of 32-bit registers. A capture interface pushes one entry per cycle. Each entry has a header part, a 16-bit payload and a kind flag that tells MSI apart from legacy INTx. The entries wait in a first-in first-out queue.

Software sees only the oldest entry. It reads the header register and then the payload register, as often as it likes. It retires the entry by writing any value to either register. Entries that arrive while the queue is full are lost, and a sticky flag records the loss. A configuration parameter marks whether the core acts as a root port. When it does not, every queue register reads as zero.

Top module: `irq_msg_window`

## Requirements
- R1: The payload register at byte address 0x15C returns the head entry's 16-bit MSI data in bits 15:0. Bits 31:16 always read as zero.
- R2: The header register at byte address 0x158 returns the following for a non-empty queue: bit 31 = 1 (entry valid), bit 30 = the sticky overflow flag, bit 29 = the kind flag (1 = INTx, 0 = MSI), and bits HDR_W-1:0 = the header part (HDR_W is 24 by default). All other bits are zero.
- R3: Reading either queue register changes neither the queue contents nor the head entry, so repeated reads return the same words.
- R4: A write to 0x158 or to 0x15C removes the head entry, whatever the write data is.
- R5: When the head entry's kind flag marks INTx, the payload register reads as zero.
- R6: With IS_ROOT = 0, every read of either queue register returns zero.
- R7: After reset the queue is empty, the overflow flag is clear, and both registers read as zero.
- R8: The queue holds DEPTH = 16 entries and returns them in arrival order. A push into a full queue without a simultaneous pop is dropped and sets the sticky overflow flag. Only reset clears that flag.
- R9: A removing write to an empty queue has no effect. While the queue is empty, both registers read as zero.
- R10: A push and a removing write in the same cycle on a non-empty queue both complete, and the entry count stays the same.
- R11: The register port always accepts requests (ready is high). A read request accepted at one clock edge returns its data with rsp_valid high after the next edge. Writes produce no response. Reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Push strobe for one interrupt message |
| msg_kind | input | 1 | Message kind: 1 = INTx, 0 = MSI |
| msg_hdr | input | HDR_W | Header part of the message |
| msg_data | input | DATA_W | MSI payload |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data (no field stores it) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Registered read data |

## Verification
A table of vectors mixes MSI and INTx entries. It tells the payload masking apart from the header kind flag, and it repeats reads to show that reads never pop. Each pop goes to one of the two addresses, which shows that both addresses retire the head entry.

Directed sequences fill the queue past capacity with distinct payloads. Draining it then separates correct ordering and drop-on-full from wrap-around errors, and shows whether the overflow flag stays set. Further sequences cover a pop on an empty queue, a push and a pop in the same cycle, an unmapped address, a write that must give no response, and a second instance built as a non-root core.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

    localparam int unsigned WORD_W = 32;

    // byte addresses of the two queue registers
    localparam logic [11:0] HDR_ADDR = 12'h158;
    localparam logic [11:0] PAY_ADDR = 12'h15C;

    // header register flag positions
    localparam int unsigned VALID_POS = 31;
    localparam int unsigned OVF_POS   = 30;
    localparam int unsigned KIND_POS  = 29;

    typedef enum logic {
        KIND_MSI  = 1'b0,
        KIND_INTX = 1'b1
    } msg_kind_e;

endpackage

// File: rtl/irq_msg_fifo.sv
module irq_msg_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned ENT_W = 41
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [ENT_W-1:0] push_ent,
    input  logic             pop,
    output logic [ENT_W-1:0] head_ent,
    output logic             empty,
    output logic             ovf
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] rd;
        logic [PW-1:0] wr;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic [ENT_W-1:0] mem_q [DEPTH];
    logic do_push, do_pop, full;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        full    = (s_q.cnt == FULL_CNT);
        do_pop  = pop && (s_q.cnt != '0);
        do_push = push && (!full || do_pop);
        if (do_push) s_d.wr = step(s_q.wr);
        if (do_pop)  s_d.rd = step(s_q.rd);
        unique case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
        if (push && !do_push) s_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wr] <= push_ent;
    end

    assign head_ent = mem_q[s_q.rd];
    assign empty    = (s_q.cnt == '0);
    assign ovf      = s_q.ovf;

    // R8: occupancy never exceeds the queue depth
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= FULL_CNT);

    // R8: a push into a full queue without a pop sets the sticky flag
    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (s_q.ovf && $stable(s_q.cnt)));

    // R9: a pop request on an empty queue leaves the read side alone
    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> ($stable(s_q.rd) && empty));

    // R10: concurrent push and pop on a non-empty queue keep the count
    assert_push_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty) |=> $stable(s_q.cnt));

endmodule

// File: rtl/irq_msg_regs.sv
module irq_msg_regs
    import irq_msg_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned HDR_W   = 24,
    parameter int unsigned DATA_W  = 16,
    parameter bit          IS_ROOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              head_kind,
    input  logic [HDR_W-1:0]  head_hdr,
    input  logic [DATA_W-1:0] head_data,
    input  logic              empty,
    input  logic              ovf,
    output logic              pop,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata
);
    localparam logic [ADDR_W-1:0] A_HDR = ADDR_W'(HDR_ADDR);
    localparam logic [ADDR_W-1:0] A_PAY = ADDR_W'(PAY_ADDR);

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } rsp_state_t;

    rsp_state_t r_d, r_q;
    logic hit_hdr, hit_pay, rd_req;
    logic [WORD_W-1:0] hdr_word, pay_word, sel_word, out_word;

    always_comb begin
        hit_hdr  = (req_addr == A_HDR);
        hit_pay  = (req_addr == A_PAY);
        rd_req   = req_valid && !req_write;
        hdr_word = '0;
        pay_word = '0;
        if (!empty) begin
            hdr_word[VALID_POS]   = 1'b1;
            hdr_word[OVF_POS]     = ovf;
            hdr_word[KIND_POS]    = head_kind;
            hdr_word[HDR_W-1:0]   = head_hdr;
            if (head_kind == KIND_MSI) pay_word[DATA_W-1:0] = head_data;
        end
        sel_word = hit_hdr ? hdr_word : (hit_pay ? pay_word : '0);
    end

    generate
        if (IS_ROOT) begin : g_root
            assign out_word = sel_word;
        end else begin : g_endpoint
            assign out_word = '0;
            // R6: a core that is not a root port never returns queue data
            assert_nonroot_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
                rsp_valid |-> (rsp_rdata == '0));
        end
    endgenerate

    always_comb begin
        r_d      = '0;
        r_d.vld  = rd_req;
        if (rd_req) r_d.data = out_word;
        pop      = req_valid && req_write && (hit_hdr || hit_pay);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid = r_q.vld;
    assign rsp_rdata = r_q.data;

    // R11: every read is answered after one edge, writes are not
    assert_read_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);
    assert_write_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);

    // R5: INTx heads never expose payload bits
    assert_intx_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && hit_pay && head_kind == KIND_INTX) |=> (rsp_rdata == '0));

    // R1: upper half of the payload word is always clear
    assert_pay_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && hit_pay) |=> (rsp_rdata[WORD_W-1:DATA_W] == '0));

    // R4: write data must be driven even though no field keeps it
    assert_wdata_known_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> !$isunknown(req_wdata));

endmodule

// File: rtl/irq_msg_window.sv
module irq_msg_window
    import irq_msg_pkg::*;
#(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned HDR_W   = 24,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 12,
    parameter bit          IS_ROOT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic              msg_kind,
    input  logic [HDR_W-1:0]  msg_hdr,
    input  logic [DATA_W-1:0] msg_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);
    localparam int unsigned ENT_W = 1 + HDR_W + DATA_W;

    logic [ENT_W-1:0] head_ent;
    logic             empty, ovf, pop;
    logic             head_kind;
    logic [HDR_W-1:0] head_hdr;
    logic [DATA_W-1:0] head_data;

    assign req_ready = 1'b1;
    assign {head_kind, head_hdr, head_data} = head_ent;

    irq_msg_fifo #(
        .DEPTH (DEPTH),
        .ENT_W (ENT_W)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (msg_valid),
        .push_ent ({msg_kind, msg_hdr, msg_data}),
        .pop      (pop),
        .head_ent (head_ent),
        .empty    (empty),
        .ovf      (ovf)
    );

    irq_msg_regs #(
        .ADDR_W  (ADDR_W),
        .HDR_W   (HDR_W),
        .DATA_W  (DATA_W),
        .IS_ROOT (IS_ROOT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .head_kind (head_kind),
        .head_hdr  (head_hdr),
        .head_data (head_data),
        .empty     (empty),
        .ovf       (ovf),
        .pop       (pop),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // R3: a read without a concurrent push leaves the head and fill state
    assert_read_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !msg_valid) |=> ($stable(head_ent) && $stable(empty)));

    // R4: a removing write on a lone-entry queue empties it
    assert_pop_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !msg_valid && !empty && u_fifo.s_q.cnt == 1) |=> empty);

endmodule

// File: tb/irq_msg_window_tb.sv
`timescale 1ns/1ps
module irq_msg_window_tb;

    localparam logic [11:0] A_HDR = 12'h158;
    localparam logic [11:0] A_PAY = 12'h15C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        msg_valid = 0, msg_kind = 0;
    logic [23:0] msg_hdr = '0;
    logic [15:0] msg_data = '0;
    logic        req_valid = 0, req_write = 0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;

    irq_msg_window u_dut (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_hdr(msg_hdr), .msg_data(msg_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    // second instance configured as a non-root core
    logic        n_msg_valid = 0;
    logic        n_req_valid = 0;
    logic [11:0] n_req_addr = '0;
    logic        n_ready, n_rsp_valid;
    logic [31:0] n_rsp_rdata;

    irq_msg_window #(.IS_ROOT(1'b0)) u_dut_nr (
        .clk(clk), .rst_n(rst_n),
        .msg_valid(n_msg_valid), .msg_kind(1'b0), .msg_hdr(24'h00C0DE), .msg_data(16'h5A5A),
        .req_valid(n_req_valid), .req_ready(n_ready), .req_write(1'b0),
        .req_addr(n_req_addr), .req_wdata(32'h0),
        .rsp_valid(n_rsp_valid), .rsp_rdata(n_rsp_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic kind, input logic [23:0] hdr, input logic [15:0] data);
        @(negedge clk);
        msg_valid = 1; msg_kind = kind; msg_hdr = hdr; msg_data = data;
        @(negedge clk);
        msg_valid = 0;
    endtask

    task automatic rd(input logic [11:0] addr, output logic [31:0] val);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = addr;
        @(negedge clk);
        req_valid = 0;
        chk("R11 rsp_valid", {31'b0, rsp_valid}, 32'd1);
        val = rsp_rdata;
    endtask

    task automatic wr(input logic [11:0] addr, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = addr; req_wdata = data;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    // op: 0 push, 1 read header, 2 read payload, 3 removing write (sel=1 header addr)
    typedef struct packed {
        logic [1:0]  op;
        logic        sel;
        logic [23:0] hdr;
        logic [15:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 24'h000AB1, 16'h1234, 32'h0},
        '{2'd0, 1'b1, 24'h000002, 16'hBEEF, 32'h0},
        '{2'd1, 1'b0, 24'h0,      16'h0,    32'h80000AB1},
        '{2'd2, 1'b0, 24'h0,      16'h0,    32'h00001234},
        '{2'd2, 1'b0, 24'h0,      16'h0,    32'h00001234},
        '{2'd3, 1'b0, 24'h0,      16'hFFFF, 32'h0},
        '{2'd1, 1'b0, 24'h0,      16'h0,    32'hA0000002},
        '{2'd2, 1'b0, 24'h0,      16'h0,    32'h00000000},
        '{2'd3, 1'b1, 24'h0,      16'h0,    32'h0},
        '{2'd1, 1'b0, 24'h0,      16'h0,    32'h00000000},
        '{2'd2, 1'b0, 24'h0,      16'h0,    32'h00000000}
    };

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R7 reset state
        chk("R7 ready", {31'b0, req_ready}, 32'd1);
        rd(A_HDR, v); chk("R7 header after reset", v, 32'h0);
        rd(A_PAY, v); chk("R7 payload after reset", v, 32'h0);

        // vector table: R1 R2 R3 R4 R5 R9
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: push(VEC[i].sel, VEC[i].hdr, VEC[i].data);
                2'd1: begin rd(A_HDR, v); chk($sformatf("R2/R3/R9 vec %0d", i), v, VEC[i].exp); end
                2'd2: begin rd(A_PAY, v); chk($sformatf("R1/R5/R9 vec %0d", i), v, VEC[i].exp); end
                default: begin
                    wr(VEC[i].sel ? A_HDR : A_PAY, {16'hDEAD, VEC[i].data});
                    chk("R11 write has no response", {31'b0, rsp_valid}, 32'd0);
                end
            endcase
        end

        // R9 removing write on empty queue, then a push must be the head
        wr(A_PAY, 32'h0);
        wr(A_HDR, 32'h1);
        push(1'b0, 24'h000777, 16'h0777);
        rd(A_PAY, v); chk("R9 pop on empty ignored", v, 32'h00000777);
        wr(A_HDR, 32'h0);
        rd(A_HDR, v); chk("R9 empty again", v, 32'h0);

        // R10 concurrent push and pop
        push(1'b0, 24'h1, 16'h0A0A);
        push(1'b0, 24'h2, 16'h0B0B);
        @(negedge clk);
        msg_valid = 1; msg_kind = 0; msg_hdr = 24'h3; msg_data = 16'h0C0C;
        req_valid = 1; req_write = 1; req_addr = A_PAY;
        @(negedge clk);
        msg_valid = 0; req_valid = 0; req_write = 0;
        rd(A_PAY, v); chk("R10 head after push+pop", v, 32'h00000B0B);
        wr(A_PAY, 32'h0);
        rd(A_PAY, v); chk("R10 pushed entry kept", v, 32'h00000C0C);
        wr(A_PAY, 32'h0);
        rd(A_HDR, v); chk("R10 count unchanged", v, 32'h0);

        // R8 fill past capacity, check order and sticky overflow
        for (int k = 0; k < 17; k++) push(1'b0, 24'(k), 16'(16'h100 + k));
        rd(A_HDR, v); chk("R8 overflow flag and head", v, 32'hC0000000);
        for (int k = 0; k < 16; k++) begin
            rd(A_PAY, v); chk($sformatf("R8 order %0d", k), v, 32'(16'h100 + k));
            wr(A_HDR, 32'hFFFFFFFF);
        end
        rd(A_HDR, v); chk("R8 dropped entry absent", v, 32'h0);
        push(1'b1, 24'h000044, 16'h9999);
        rd(A_HDR, v); chk("R8 overflow sticky", v, 32'hE0000044);
        rd(A_PAY, v); chk("R5 INTx payload zero", v, 32'h0);
        wr(A_HDR, 32'h0);

        // R11 unmapped address
        push(1'b0, 24'h55, 16'h55);
        rd(12'h160, v); chk("R11 unmapped reads zero", v, 32'h0);

        // R6 non-root instance
        @(negedge clk); n_msg_valid = 1;
        @(negedge clk); n_msg_valid = 0;
        @(negedge clk); n_req_valid = 1; n_req_addr = A_HDR;
        @(negedge clk); n_req_addr = A_PAY;
        chk("R6 header rsp_valid", {31'b0, n_rsp_valid}, 32'd1);
        chk("R6 header zero", n_rsp_rdata, 32'h0);
        @(negedge clk); n_req_valid = 0;
        chk("R6 payload zero", n_rsp_rdata, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule